// File: doc/BRIEF.md
# LPC Bus Master Grant Encoder

This block is the host-side arbiter for LPC bus mastering with two peripheral masters. Each master asks for the bus by sending a short serial frame on its own active-low request line. The frame has a low start bit, three channel bits sent least significant bit first, and an active bit. The block keeps one pending flag per master. When the bus is idle it picks a pending master, drives a one-clock START nibble with LFRAME# low, and then releases LAD so the granted master can run its cycle.

The START nibble depends only on which request line won, so no configuration is needed. Master 0 gets 0010b and master 1 gets 0011b. In the clock after START the master places its cycle type on LAD[3:2], and the block samples it there. A memory cycle keeps the bus owned until the master's cycle-done indication. Any other type, such as I/O or DMA, is refused with an abort pattern.

Top module: `lpc_gnt_encoder`

## Requirements
- R1: While reset is asserted and right after it is released, `lframe_n` is 1, `lad_oe` is 0 and `bus_busy` is 0.
- R2: A request frame on `ldrq_n[m]` has five bits in this order: a 0 start bit, channel bits 0, 1 and 2, then an active bit equal to 1. Starting from an idle bus, the START nibble appears in the second clock period after the period that carries the active bit. `lframe_n` stays high in the period between them.
- R3: START lasts exactly one clock, with `lframe_n`=0, `lad_oe`=1 and `lad_out`=0010b for master 0 or 0011b for master 1.
- R4: From the START period until the bus is idle again, `owner_id` shows the granted master and `owner_chan` shows the channel from that master's frame.
- R5: When both masters are pending, the master other than the last one granted wins. After reset, master 0 counts as the one to serve first.
- R6: A request that completes while the other master owns the bus stays pending. It is granted in the second period after the owner's cycle ends.
- R7: A frame whose active bit is 0 clears that master's pending request, so no grant follows.
- R8: In the clock after START, `lad_oe`=0 and `lframe_n`=1, and `lad_type` is sampled. Value 01b (memory) keeps `bus_busy` high until `cyc_done` is sampled at 1. The bus is idle in the next period.
- R9: Any other `lad_type` value (00b I/O, 10b DMA, 11b reserved) is refused. For exactly 4 clocks the block drives `lframe_n`=0, `lad_oe`=1 and `lad_out`=1111b, ignoring `cyc_done`, and then returns to idle.
- R10: No START or abort pattern is driven while a master owns the bus, and `lframe_n` is never low while `bus_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LPC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ldrq_n | input | 2 | Serial request line per master, active low |
| lad_type | input | 2 | LAD[3:2] as driven by the master in the clock after START |
| cyc_done | input | 1 | Granted master's cycle has ended |
| lframe_n | output | 1 | Frame strobe, active low |
| lad_out | output | 4 | Nibble driven on LAD |
| lad_oe | output | 1 | LAD output enable |
| bus_busy | output | 1 | A grant sequence or ownership is in progress |
| owner_id | output | 1 | Index of the granted master |
| owner_chan | output | 3 | Channel field of the granted request |

## Verification
A request's pending flag is registered at the edge that samples its active bit. The idle state machine reacts one edge later, so START falls two periods after the active bit. The bench drives inputs on falling edges and samples at the next falling edge inside the period it expects. The type phase comes one period after START. Ownership ends one period after `cyc_done` is sampled, and an abort spans exactly four periods, so each check is placed on the exact period where the result is due rather than in a window. Sweeps cover every channel on both masters, every refused type, both round-robin orders and the cancel case.

// File: rtl/lpc_gnt_pkg.sv
package lpc_gnt_pkg;
  // START nibble for master k is START_BASE + k
  localparam logic [3:0] START_BASE = 4'b0010;
  localparam logic [3:0] ABORT_NIB  = 4'b1111;
  localparam logic [1:0] TYPE_MEM   = 2'b01;

  typedef enum logic [2:0] {
    G_IDLE,
    G_START,
    G_TYPE,
    G_OWN,
    G_ABORT
  } gnt_st_e;

  typedef enum logic [1:0] {
    Q_IDLE,
    Q_CHAN,
    Q_ACT
  } req_st_e;
endpackage

// File: rtl/lpc_ldrq_decoder.sv
module lpc_ldrq_decoder
  import lpc_gnt_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ldrq_n,
  output logic            frame_vld,
  output logic            frame_act,
  output logic [CH_W-1:0] chan
);
  localparam int CNT_W = (CH_W > 1) ? $clog2(CH_W) : 1;

  req_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CH_W-1:0]  chan_q, chan_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    chan_d = chan_q;
    case (st_q)
      Q_IDLE: begin
        if (!ldrq_n) begin
          st_d  = Q_CHAN;
          cnt_d = '0;
        end
      end
      Q_CHAN: begin
        chan_d[cnt_q] = ldrq_n;
        if (cnt_q == CNT_W'(CH_W - 1)) st_d = Q_ACT;
        else                           cnt_d = cnt_q + 1'b1;
      end
      default: st_d = Q_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= Q_IDLE;
      cnt_q  <= '0;
      chan_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      chan_q <= chan_d;
    end
  end

  assign frame_vld = (st_q == Q_ACT);
  assign frame_act = ldrq_n;
  assign chan      = chan_q;
endmodule

// File: rtl/lpc_rr_pick.sv
module lpc_rr_pick #(
  parameter int N_MST = 2,
  parameter int IDW   = 1
) (
  input  logic [N_MST-1:0] pend,
  input  logic [IDW-1:0]   last,
  output logic             any,
  output logic [IDW-1:0]   sel
);
  always_comb begin
    logic found;
    found = 1'b0;
    sel   = '0;
    for (int k = 1; k <= N_MST; k++) begin
      int idx;
      idx = (int'(last) + k) % N_MST;
      if (!found && pend[idx]) begin
        sel   = IDW'(idx);
        found = 1'b1;
      end
    end
    any = |pend;
  end
endmodule

// File: rtl/lpc_gnt_encoder.sv
module lpc_gnt_encoder
  import lpc_gnt_pkg::*;
#(
  parameter int N_MST     = 2,
  parameter int CH_W      = 3,
  parameter int ABORT_LEN = 4,
  localparam int IDW      = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MST-1:0] ldrq_n,
  input  logic [1:0]       lad_type,
  input  logic             cyc_done,
  output logic             lframe_n,
  output logic [3:0]       lad_out,
  output logic             lad_oe,
  output logic             bus_busy,
  output logic [IDW-1:0]   owner_id,
  output logic [CH_W-1:0]  owner_chan
);
  localparam int AB_W = (ABORT_LEN > 1) ? $clog2(ABORT_LEN) : 1;

  logic [N_MST-1:0] frame_vld, frame_act;
  logic [CH_W-1:0]  chan_arr [N_MST];
  logic [N_MST-1:0] pend_q, pend_d;
  logic             any;
  logic [IDW-1:0]   sel;
  logic             grant;

  gnt_st_e          st_q, st_d;
  logic [AB_W-1:0]  ab_q, ab_d;
  logic [IDW-1:0]   last_q, id_q;
  logic [CH_W-1:0]  chan_q;

  for (genvar g = 0; g < N_MST; g++) begin : g_dec
    lpc_ldrq_decoder #(.CH_W(CH_W)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .ldrq_n    (ldrq_n[g]),
      .frame_vld (frame_vld[g]),
      .frame_act (frame_act[g]),
      .chan      (chan_arr[g])
    );

    // grant clears, a completed frame overrides
    always_comb begin
      pend_d[g] = pend_q[g];
      if (grant && (sel == IDW'(g))) pend_d[g] = 1'b0;
      if (frame_vld[g])              pend_d[g] = frame_act[g];
    end
  end

  lpc_rr_pick #(.N_MST(N_MST), .IDW(IDW)) u_pick (
    .pend (pend_q),
    .last (last_q),
    .any  (any),
    .sel  (sel)
  );

  assign grant = (st_q == G_IDLE) && any;

  always_comb begin
    st_d = st_q;
    ab_d = ab_q;
    case (st_q)
      G_IDLE:  if (any) st_d = G_START;
      G_START: st_d = G_TYPE;
      G_TYPE: begin
        if (lad_type == TYPE_MEM) st_d = G_OWN;
        else begin
          st_d = G_ABORT;
          ab_d = '0;
        end
      end
      G_OWN:   if (cyc_done) st_d = G_IDLE;
      G_ABORT: begin
        if (ab_q == AB_W'(ABORT_LEN - 1)) st_d = G_IDLE;
        else                              ab_d = ab_q + 1'b1;
      end
      default: st_d = G_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= G_IDLE;
      ab_q   <= '0;
      pend_q <= '0;
    end else begin
      st_q   <= st_d;
      ab_q   <= ab_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= IDW'(N_MST - 1);
      id_q   <= '0;
      chan_q <= '0;
    end else if (grant) begin
      last_q <= sel;
      id_q   <= sel;
      chan_q <= chan_arr[sel];
    end
  end

  always_comb begin
    lframe_n = 1'b1;
    lad_oe   = 1'b0;
    lad_out  = '0;
    if (st_q == G_START) begin
      lframe_n = 1'b0;
      lad_oe   = 1'b1;
      lad_out  = 4'(START_BASE + 4'(id_q));
    end else if (st_q == G_ABORT) begin
      lframe_n = 1'b0;
      lad_oe   = 1'b1;
      lad_out  = ABORT_NIB;
    end
  end

  assign bus_busy   = (st_q != G_IDLE);
  assign owner_id   = id_q;
  assign owner_chan = chan_q;
endmodule

// File: rtl/lpc_gnt_encoder_chk.sv
module lpc_gnt_encoder_chk #(
  parameter int IDW = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     lad_type,
  input logic           lframe_n,
  input logic [3:0]     lad_out,
  input logic           lad_oe,
  input logic           bus_busy,
  input logic [IDW-1:0] owner_id
);
  logic is_start;
  assign is_start = !lframe_n && (lad_out != 4'hF);

  p_start_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_start |-> (lad_out == 4'(4'b0010 + 4'(owner_id))));

  p_start_one_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_start |=> (lframe_n && !lad_oe));

  p_mem_own_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_start ##1 (lad_type == 2'b01) |=> (bus_busy && lframe_n && !lad_oe));

  p_io_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_start ##1 (lad_type != 2'b01) |=> (!lframe_n && lad_oe && lad_out == 4'hF));

  p_frame_needs_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |-> bus_busy);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy |-> (lframe_n && !lad_oe));
endmodule

bind lpc_gnt_encoder lpc_gnt_encoder_chk #(.IDW(IDW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lad_type (lad_type),
  .lframe_n (lframe_n),
  .lad_out  (lad_out),
  .lad_oe   (lad_oe),
  .bus_busy (bus_busy),
  .owner_id (owner_id)
);

// File: tb/lpc_gnt_encoder_test.sv
module lpc_gnt_encoder_test;
  logic       clk;
  logic       rst_n;
  logic [1:0] ldrq_n;
  logic [1:0] lad_type;
  logic       cyc_done;
  logic       lframe_n;
  logic [3:0] lad_out;
  logic       lad_oe;
  logic       bus_busy;
  logic [0:0] owner_id;
  logic [2:0] owner_chan;

  int n_chk = 0;
  int n_fail = 0;

  lpc_gnt_encoder uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ldrq_n     (ldrq_n),
    .lad_type   (lad_type),
    .cyc_done   (cyc_done),
    .lframe_n   (lframe_n),
    .lad_out    (lad_out),
    .lad_oe     (lad_oe),
    .bus_busy   (bus_busy),
    .owner_id   (owner_id),
    .owner_chan (owner_chan)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic fbit(input int b, input logic [2:0] c, input logic a);
    if (b == 0)     return 1'b0;
    else if (b < 4) return c[b-1];
    else            return a;
  endfunction

  // five-bit request frames; returns mid period after the active bit
  task automatic send(input logic [1:0] en, input logic [2:0] c0, input logic [2:0] c1,
                      input logic a0, input logic a1);
    for (int b = 0; b < 5; b++) begin
      @(negedge clk);
      ldrq_n[0] = en[0] ? fbit(b, c0, a0) : 1'b1;
      ldrq_n[1] = en[1] ? fbit(b, c1, a1) : 1'b1;
    end
    @(negedge clk);
    ldrq_n = 2'b11;
  endtask

  task automatic expect_start(input int m, input logic [2:0] ch, input logic [1:0] typ);
    @(negedge clk);
    chk(lframe_n == 1'b0, "R3 lframe_n at START", int'(lframe_n), 0);
    chk(lad_oe == 1'b1, "R3 lad_oe at START", int'(lad_oe), 1);
    chk(lad_out == 4'(2 + m), "R3 START code", int'(lad_out), 2 + m);
    chk(owner_id == 1'(m), "R4 owner_id", int'(owner_id), m);
    chk(owner_chan == ch, "R4 owner_chan", int'(owner_chan), int'(ch));
    lad_type = typ;
  endtask

  task automatic type_phase();
    @(negedge clk);
    chk(lframe_n && !lad_oe && bus_busy, "R8 type phase released",
        int'({lframe_n, lad_oe, bus_busy}), 3'b101);
  endtask

  task automatic own_finish();
    @(negedge clk);
    chk(bus_busy && lframe_n && !lad_oe, "R8 owned", int'({bus_busy, lframe_n, lad_oe}), 3'b110);
    @(negedge clk);
    chk(bus_busy && lframe_n, "R8 held without done", int'({bus_busy, lframe_n}), 2'b11);
    cyc_done = 1'b1;
    @(negedge clk);
    cyc_done = 1'b0;
    chk(!bus_busy, "R8 idle after done", int'(bus_busy), 0);
  endtask

  task automatic abort_phase();
    cyc_done = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!lframe_n && lad_oe && lad_out == 4'hF, "R9 abort pattern",
          int'({lframe_n, lad_oe, lad_out}), 6'b011111);
    end
    @(negedge clk);
    cyc_done = 1'b0;
    chk(!bus_busy && lframe_n, "R9 idle after abort", int'({bus_busy, lframe_n}), 2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [1:0] bad_types [4];
    bad_types[0] = 2'b00;
    bad_types[1] = 2'b10;
    bad_types[2] = 2'b11;
    bad_types[3] = 2'b00;
    rst_n    = 1'b0;
    ldrq_n   = 2'b11;
    lad_type = 2'b00;
    cyc_done = 1'b0;
    repeat (3) @(negedge clk);
    chk(lframe_n && !lad_oe && !bus_busy, "R1 in reset", int'({lframe_n, lad_oe, bus_busy}), 3'b100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(lframe_n && !lad_oe && !bus_busy, "R1 after reset", int'({lframe_n, lad_oe, bus_busy}), 3'b100);

    // R2/R3/R4/R8: every channel on each master
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 8; c++) begin
        send(2'(1 << m), 3'(c), 3'(c), 1'b1, 1'b1);
        chk(lframe_n == 1'b1, "R2 no START in gap period", int'(lframe_n), 1);
        expect_start(m, 3'(c), 2'b01);
        type_phase();
        own_finish();
      end
    end

    // R5: last granted was master 1, so master 0 first
    send(2'b11, 3'd5, 3'd6, 1'b1, 1'b1);
    expect_start(0, 3'd5, 2'b01);
    type_phase();
    own_finish();
    expect_start(1, 3'd6, 2'b01);   // R6 other request kept
    type_phase();
    own_finish();

    // R5: after master 0 alone, a tie goes to master 1
    send(2'b01, 3'd3, 3'd0, 1'b1, 1'b1);
    expect_start(0, 3'd3, 2'b01);
    type_phase();
    own_finish();
    send(2'b11, 3'd1, 3'd2, 1'b1, 1'b1);
    expect_start(1, 3'd2, 2'b01);
    type_phase();
    own_finish();
    expect_start(0, 3'd1, 2'b01);
    type_phase();
    own_finish();

    // R6/R10: request arrives during ownership
    send(2'b01, 3'd4, 3'd0, 1'b1, 1'b1);
    expect_start(0, 3'd4, 2'b01);
    type_phase();
    send(2'b10, 3'd0, 3'd7, 1'b1, 1'b1);
    chk(lframe_n && bus_busy, "R10 no START while owned", int'({lframe_n, bus_busy}), 2'b11);
    @(negedge clk);
    chk(lframe_n && bus_busy, "R10 still owned", int'({lframe_n, bus_busy}), 2'b11);
    cyc_done = 1'b1;
    @(negedge clk);
    cyc_done = 1'b0;
    chk(!bus_busy, "R8 idle after done", int'(bus_busy), 0);
    expect_start(1, 3'd7, 2'b01);
    type_phase();
    own_finish();

    // R7: request then cancel while other master owns the bus
    send(2'b10, 3'd0, 3'd3, 1'b1, 1'b1);
    expect_start(1, 3'd3, 2'b01);
    type_phase();
    send(2'b01, 3'd6, 3'd0, 1'b1, 1'b1);
    send(2'b01, 3'd6, 3'd0, 1'b0, 1'b1);
    cyc_done = 1'b1;
    @(negedge clk);
    cyc_done = 1'b0;
    chk(!bus_busy, "R8 idle after done", int'(bus_busy), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(lframe_n && !bus_busy, "R7 cancelled request not granted",
          int'({lframe_n, bus_busy}), 2'b10);
    end

    // R9: refused cycle types on both masters
    for (int t = 0; t < 4; t++) begin
      send(2'(1 << (t % 2)), 3'(t), 3'(t + 1), 1'b1, 1'b1);
      expect_start(t % 2, (t % 2 == 0) ? 3'(t) : 3'(t + 1), bad_types[t]);
      type_phase();
      abort_phase();
    end

    // bus usable again after an abort
    send(2'b01, 3'd2, 3'd0, 1'b1, 1'b1);
    expect_start(0, 3'd2, 2'b01);
    type_phase();
    own_finish();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule